// File: doc/BRIEF.md
# Terminal-Count Interrupt Counter

This block is one channel of a programmable interval counter, reduced to the event-counting behaviour. A processor programs it over a byte-wide write port. A control write arms the channel and pulls the output low. Two count-byte writes then give the 16-bit start value, least significant byte first. From the clock after the final byte, every counting tick that arrives while the gate input is high takes one off the count. When the count reaches zero the output goes high and stays high. That rising edge is meant to drive a processor interrupt line.

Counting ticks arrive as single-cycle strobes on `tick`, synchronous to the system clock. While `gate` is low, ticks are ignored and the count is held. Counting carries on from the held value once the gate is high again. A start value of zero counts as 65536 ticks. After terminal count the counter keeps counting and wraps, but the output does not move until software writes to the channel again. A new control word or count byte at any time stops counting and pulls the output low. The byte order restarts after every control write.

Top module: `tc_irq_counter`

## Requirements
- R1: After reset, `term_out` is 0 and the channel is idle: ticks do not raise `term_out`.
- R2: A control write (`wr_en`=1, `wr_ctrl`=1; the data byte is ignored) makes `term_out` 0 from the next cycle on, whatever its previous value.
- R3: A count write (`wr_en`=1, `wr_ctrl`=0) puts `wr_data` into the start value. The first count write after a control write fills bits 7:0 and the second fills bits 15:8. Counting begins with ticks in the cycles after the second write. A tick in the same cycle as that write is not counted.
- R4: With the gate high throughout, a start value N (1..65535) makes `term_out` rise in the cycle after the N-th counted tick, and not earlier.
- R5: A tick with `gate`=0 is not counted. The count is held and counting resumes from the held value, so `term_out` rises after N ticks taken with `gate`=1.
- R6: Once high, `term_out` stays 1 through any further ticks (the count wraps from 0 to 0xFFFF) until the next control or count write.
- R7: A count write while counting pulls `term_out` to 0 in the next cycle and halts counting. After the second byte, the new start value is counted from scratch.
- R8: A start value of 0 makes `term_out` rise after exactly 65536 counted ticks.
- R9: Count writes that arrive after reset but before any control write are ignored: ticks that follow leave `term_out` at 0.
- R10: A control write between the two count bytes discards the partial value, so the next count write again fills bits 7:0.
- R11: A control write while counting halts counting. `term_out` stays 0 through later ticks until a full new count is written and counted down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe from the processor, one cycle per byte |
| wr_ctrl | input | 1 | 1: control write, 0: count byte write |
| wr_data | input | 8 | Write data byte |
| tick | input | 1 | Counting strobe, one cycle per count event |
| gate | input | 1 | Counting enable; ticks are ignored while low |
| term_out | output | 1 | Terminal-count output; low while counting, high once zero is reached |

## Verification
The assertions take for granted that at most one write arrives per cycle. They also assume `tick` and `gate` are synchronous strobes that settle before the clock edge. There is no rule tying ticks to writes: a tick may coincide with the final count byte or with a control write, and the properties then give the write priority. The bench drives every input on the falling clock edge and issues writes one at a time. It deliberately places ticks on write cycles and gate-low cycles, so that the ignored-tick paths are exercised within those assumptions.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    // Channel sequencing state
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,   // no control word since reset
        SEQ_LOAD = 2'd1,   // collecting count bytes
        SEQ_RUN  = 2'd2    // counting
    } seq_state_e;

    // Control strobes from the write sequencer to the datapath
    typedef struct packed {
        logic load;   // full start value present this cycle
        logic run;    // counting is permitted
        logic arm;    // a write that pulls the output low
    } seq_ctl_t;

    // Number of bytes needed to fill a count of the given width
    function automatic int unsigned bytes_for(input int unsigned cnt_w,
                                              input int unsigned byte_w);
        return (cnt_w + byte_w - 1) / byte_w;
    endfunction

    // Index width for a byte counter
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tcc_seq.sv
module tcc_seq
    import tcc_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    output seq_ctl_t          ctl,
    output logic [CNT_W-1:0]  load_val
);
    localparam int unsigned NUM_BYTES = bytes_for(CNT_W, BYTE_W);
    localparam int unsigned IDX_W     = idx_bits(NUM_BYTES);
    localparam int unsigned LAST      = NUM_BYTES - 1;

    seq_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             ctrl_wr;
    logic             data_acc;
    logic             last_byte;

    assign ctrl_wr   = wr_en && wr_ctrl;
    assign data_acc  = wr_en && !wr_ctrl && (state_q != SEQ_IDLE);
    assign last_byte = (idx_q == IDX_W'(LAST));

    assign ctl.load = data_acc && last_byte;
    assign ctl.run  = (state_q == SEQ_RUN);
    assign ctl.arm  = ctrl_wr || data_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
        end else if (ctrl_wr) begin
            state_q <= SEQ_LOAD;
            idx_q   <= '0;
        end else if (data_acc) begin
            if (last_byte) begin
                state_q <= SEQ_RUN;
                idx_q   <= '0;
            end else begin
                state_q <= SEQ_LOAD;
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

    // One lane per byte of the start value; the final byte goes straight through
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
        localparam int unsigned LO = k * BYTE_W;
        localparam int unsigned SW = ((LO + BYTE_W) > CNT_W) ? (CNT_W - LO) : BYTE_W;
        if (k == LAST) begin : g_direct
            assign load_val[LO +: SW] = wr_data[SW-1:0];
        end else begin : g_held
            logic [SW-1:0] lane_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    lane_q <= '0;
                end else if (data_acc && (idx_q == IDX_W'(k))) begin
                    lane_q <= wr_data[SW-1:0];
                end
            end
            assign load_val[LO +: SW] = lane_q;
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        idx_q <= IDX_W'(LAST)); // R3
    AST_CTRL_RESTART: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ctrl) |=> (state_q == SEQ_LOAD) && (idx_q == '0)); // R10
    AST_IDLE_IGNORES_DATA: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_IDLE) && !(wr_en && wr_ctrl) |=> (state_q == SEQ_IDLE)); // R9
    AST_LOAD_ENTERS_RUN: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (state_q == SEQ_RUN)); // R3
    AST_DATA_WHILE_RUN_STOPS: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_RUN) && wr_en && !wr_ctrl && (LAST != 0) |=> (state_q == SEQ_LOAD)); // R7

endmodule

// File: rtl/tcc_down.sv
module tcc_down #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic             tick,
    input  logic             gate,
    input  logic [CNT_W-1:0] load_val,
    output logic             tc_hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    assign step   = run && tick && gate;
    assign tc_hit = step && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= cnt_q - ONE;   // wraps from 0 to all ones
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val))); // R3
    AST_STEP_DEC: assert property (@(posedge clk) disable iff (rst)
        run && tick && gate && !load |=> (cnt_q == $past(cnt_q) - ONE)); // R4
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !gate && !load |=> $stable(cnt_q)); // R5
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run && !load |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/tcc_out.sv
module tcc_out (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic tc_hit,
    output logic term_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            term_out <= 1'b0;
        end else if (arm) begin
            term_out <= 1'b0;
        end else if (tc_hit) begin
            term_out <= 1'b1;
        end
    end

    AST_ARM_LOW: assert property (@(posedge clk) disable iff (rst)
        arm |=> !term_out); // R2
    AST_RISE_AT_TC: assert property (@(posedge clk) disable iff (rst)
        $rose(term_out) |-> $past(tc_hit)); // R4
    AST_HIGH_STICKY: assert property (@(posedge clk) disable iff (rst)
        term_out && !arm |=> term_out); // R6

endmodule

// File: rtl/tc_irq_counter.sv
module tc_irq_counter
    import tcc_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              tick,
    input  logic              gate,
    output logic              term_out
);
    seq_ctl_t         ctl;
    logic [CNT_W-1:0] load_val;
    logic             tc_hit;

    tcc_seq #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_ctrl  (wr_ctrl),
        .wr_data  (wr_data),
        .ctl      (ctl),
        .load_val (load_val)
    );

    tcc_down #(.CNT_W(CNT_W)) u_down (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.load),
        .run      (ctl.run),
        .tick     (tick),
        .gate     (gate),
        .load_val (load_val),
        .tc_hit   (tc_hit)
    );

    tcc_out u_out (
        .clk      (clk),
        .rst      (rst),
        .arm      (ctl.arm),
        .tc_hit   (tc_hit),
        .term_out (term_out)
    );

    AST_TC_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        tc_hit |-> ctl.run && gate && tick); // R5

endmodule

// File: tb/tc_irq_counter_bench.sv
`timescale 1ns/1ps
module tc_irq_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b0;
    logic       gate = 1'b1;
    logic       term_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tc_irq_counter u_tc_irq_counter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
        .wr_data(wr_data), .tick(tick), .gate(gate), .term_out(term_out)
    );

    // {start value, tick index at which gate drops (FF = never), gate-low ticks}
    localparam int NV = 5;
    localparam logic [31:0] VEC [NV] = '{
        {16'h0001, 8'hFF, 8'd0},
        {16'h0002, 8'd1,  8'd3},
        {16'h0005, 8'd3,  8'd2},
        {16'h0100, 8'h80, 8'd4},
        {16'h0123, 8'd0,  8'd2}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: term_out actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_ctrl = c; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic load(input logic [15:0] v);
        wr(1'b0, v[7:0]);
        wr(1'b0, v[15:8]);
    endtask

    task automatic pulse(input logic g);
        @(negedge clk); tick = 1'b1; gate = g;
        @(negedge clk); tick = 1'b0; gate = 1'b1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) pulse(1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, ticks do nothing
        check("R1 reset", term_out, 1'b0);
        ticks(3);
        check("R1 idle ticks", term_out, 1'b0);

        // R9: count writes before any control write are ignored
        load(16'h0002);
        ticks(4);
        check("R9 ignored count", term_out, 1'b0);

        // Table: R3/R4/R5 under several start values and gate patterns
        for (int v = 0; v < NV; v++) begin
            logic [15:0] n  = VEC[v][31:16];
            logic [7:0]  pa = VEC[v][15:8];
            logic [7:0]  pl = VEC[v][7:0];
            wr(1'b1, 8'h5A);
            load(n);
            check("R3 loaded low", term_out, 1'b0);
            for (int t = 0; t < int'(n); t++) begin
                if (t == int'(pa)) begin
                    for (int p = 0; p < int'(pl); p++) pulse(1'b0);
                    check("R5 gate low held", term_out, 1'b0);
                end
                if (t == int'(n) - 1) check("R4 before last tick", term_out, 1'b0);
                pulse(1'b1);
            end
            check("R4 terminal count", term_out, 1'b1);
        end

        // R6: stays high through wrap, R2: control write pulls low
        ticks(5);
        check("R6 sticky high", term_out, 1'b1);
        wr(1'b1, 8'h00);
        check("R2 control low", term_out, 1'b0);

        // R3: tick in the same cycle as the final byte is not counted
        wr(1'b0, 8'h02);
        @(negedge clk); wr_en = 1'b1; wr_ctrl = 1'b0; wr_data = 8'h00; tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick = 1'b0;
        pulse(1'b1);
        check("R3 same-cycle tick", term_out, 1'b0);
        pulse(1'b1);
        check("R3 count of two", term_out, 1'b1);

        // R10: control write between bytes restarts the byte order
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h40);
        wr(1'b1, 8'h00);
        load(16'h0002);
        pulse(1'b1);
        check("R10 restart low", term_out, 1'b0);
        pulse(1'b1);
        check("R10 restart two", term_out, 1'b1);

        // R7: count write while counting halts and reloads
        wr(1'b1, 8'h00);
        load(16'h000A);
        ticks(4);
        wr(1'b0, 8'h03);
        check("R7 write pulls low", term_out, 1'b0);
        ticks(12);
        check("R7 halted", term_out, 1'b0);
        wr(1'b0, 8'h00);
        ticks(2);
        check("R7 new value low", term_out, 1'b0);
        pulse(1'b1);
        check("R7 new value done", term_out, 1'b1);

        // R11: control write while counting halts
        wr(1'b1, 8'h00);
        load(16'h0002);
        pulse(1'b1);
        wr(1'b1, 8'h00);
        ticks(5);
        check("R11 halted by control", term_out, 1'b0);
        load(16'h0001);
        pulse(1'b1);
        check("R11 reload counts", term_out, 1'b1);

        // R8: start value 0 means 65536 ticks
        wr(1'b1, 8'h00);
        load(16'h0000);
        @(negedge clk); tick = 1'b1; gate = 1'b1;
        repeat (65535) @(negedge clk);
        tick = 1'b0;
        check("R8 after 65535", term_out, 1'b0);
        pulse(1'b1);
        check("R8 after 65536", term_out, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: requirement none, actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule